// File: doc/BRIEF.md
# Parallel Port Host-Signal Interrupt Unit

This block sits on the peripheral side of an IEEE 1284 parallel port. It brings the four host control lines (select-in, strobe, init and auto-feed, all active low) into the system clock domain, removes short glitches with a digital filter and exposes the filtered levels to software. A rising and a falling edge on each filtered line each raise their own event. The data bus is captured when the filtered strobe falls, whether or not hardware handshaking is enabled.

Five more event sources arrive as one-cycle pulses from an external handshake engine: data received, command received, invalid transition, reverse data sent and host time-out. Every event has a status bit and an enable bit, and a single interrupt request is raised while any enabled status bit is set. Software may force the BUSY and ACKn outputs, which merge the force bits with the engine's outputs, and it may send a one-cycle reset pulse to the engine.

A simple CPU port (write strobe, read strobe, address, write data, combinational read data) reaches five registers: pin levels and force bits (address 0), control (address 1), latched data (address 2), status (address 3) and enable (address 4).

Top module: `pp_host_irq`

## Requirements
- R1: After reset the status and enable registers read 0, the pin level field reads 4'hF, the mode bit reads 0, irq and sm_reset are 0, busy equals eng_busy and ack_n equals the inverse of eng_ack.
- R2: Pin levels appear at address 0 bits [3:0] in the order select-in (bit 0), strobe (bit 1), init (bit 2), auto-feed (bit 3); a new pin level shows there 6 clock edges after it reaches the pin, and a pulse lasting only 2 clock cycles is ignored while one lasting 3 cycles is accepted.
- R3: A rising filtered level on pin i sets status bit i and a falling one sets status bit 4+i, on the clock edge after the level changes at address 0.
- R4: An eng_evt pulse sets status bits 8..12 on the next clock edge, with eng_evt[0..4] meaning data received, command received, invalid transition, reverse data sent, host time-out.
- R5: Writing 1 to a status bit at address 3 clears it, except bits 1 and 5 (the strobe events), on which such a write has no effect; writing 0 leaves bits unchanged.
- R6: Status bits 1 and 5 are cleared by a read of the latched data at address 2 (reg_rd with reg_addr 2).
- R7: The data bus is latched on the falling edge of the filtered strobe level and reads at address 2 bits [7:0]; later changes of the bus while strobe stays low do not alter it; capture happens with the mode bit (address 1 bit 1) at either value.
- R8: The enable register at address 4 holds bits [12:0]; bits 15..13 of the status and enable registers read 0; irq is high exactly while some status bit and its enable are both set.
- R9: busy is the OR of eng_busy and the force-busy bit at address 0 bit 8.
- R10: ack_n is the NOR of eng_ack and the force-ack bit at address 0 bit 9.
- R11: Writing 1 to address 1 bit 0 makes sm_reset high for exactly the one cycle after the write; address 1 bit 1 is a stored mode bit driven on hs_mode.
- R12: When an event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slctin_n | input | 1 | Host select-in line, active low |
| strobe_n | input | 1 | Host data strobe, active low |
| init_n | input | 1 | Host init line, active low |
| autofd_n | input | 1 | Host auto-feed line, active low |
| pdata | input | DATA_W | Parallel data bus from host |
| eng_evt | input | 5 | Event pulses from the handshake engine |
| eng_busy | input | 1 | BUSY from the handshake engine |
| eng_ack | input | 1 | Acknowledge from the handshake engine, active high |
| busy | output | 1 | BUSY pin to host |
| ack_n | output | 1 | ACKn pin to host |
| sm_reset | output | 1 | One-cycle reset pulse to the handshake engine |
| hs_mode | output | 1 | Hardware handshake enable bit |
| irq | output | 1 | Interrupt request |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |

## Verification
The hardest situation to reach is an event arriving in the very cycle software clears it, because a pin edge only surfaces six edges after the pin moves. The bench uses the engine event inputs, whose status bit sets one edge after the pulse, to line the event up exactly with a write-1-to-clear on the same bit. Filter boundaries are reached by holding a pin low for exactly two and then exactly three clock cycles, with the pins driven on falling clock edges so the count of samples is fixed.

// File: rtl/pp_host_irq.sv
module pp_host_irq #(
  parameter int DATA_W   = 8,
  parameter int SYNC_LEN = 2,
  parameter int FILT_LEN = 3,
  parameter int REG_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slctin_n,
  input  logic              strobe_n,
  input  logic              init_n,
  input  logic              autofd_n,
  input  logic [DATA_W-1:0] pdata,
  input  logic [4:0]        eng_evt,
  input  logic              eng_busy,
  input  logic              eng_ack,
  output logic              busy,
  output logic              ack_n,
  output logic              sm_reset,
  output logic              hs_mode,
  output logic              irq,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  localparam int NPIN    = 4;
  localparam int NENG    = 5;
  localparam int NEVT    = 2*NPIN + NENG;
  localparam int STB_IDX = 1;
  localparam int FBSY_BIT = 8;
  localparam int FACK_BIT = 9;
  localparam logic [2:0] A_LVL = 3'd0, A_CTL = 3'd1, A_DAT = 3'd2,
                         A_STS = 3'd3, A_EN  = 3'd4;
  localparam logic [NEVT-1:0] STB_MASK =
    (NEVT'(1) << STB_IDX) | (NEVT'(1) << (NPIN + STB_IDX));

  logic [SYNC_LEN-1:0][NPIN-1:0]   sync_q;
  logic [SYNC_LEN-1:0][DATA_W-1:0] pd_q;
  logic [NPIN-1:0]   samp, lvl, lvl_d, rise, fall;
  logic [NEVT-1:0]   sts, en, evt, clr;
  logic [DATA_W-1:0] data_q;
  logic              fbusy, fack, mode_q, rst_q;
  logic              wr_lvl, wr_ctl, wr_sts, wr_en, rd_dat;
  logic              unused_wdata;

  assign samp = sync_q[SYNC_LEN-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '1;
      pd_q   <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_LEN-2:0], {autofd_n, init_n, strobe_n, slctin_n}};
      pd_q   <= {pd_q[SYNC_LEN-2:0], pdata};
    end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [FILT_LEN-1:0] hist;
    logic                lv;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        hist <= '1;
        lv   <= 1'b1;
      end else begin
        hist <= {hist[FILT_LEN-2:0], samp[g]};
        if (hist == '1)      lv <= 1'b1;
        else if (hist == '0) lv <= 1'b0;
      end
    assign lvl[g] = lv;
  end

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
  assign evt  = {eng_evt, fall, rise};

  assign wr_lvl = reg_wr && reg_addr == A_LVL;
  assign wr_ctl = reg_wr && reg_addr == A_CTL;
  assign wr_sts = reg_wr && reg_addr == A_STS;
  assign wr_en  = reg_wr && reg_addr == A_EN;
  assign rd_dat = reg_rd && reg_addr == A_DAT;

  assign clr = (wr_sts ? (reg_wdata[NEVT-1:0] & ~STB_MASK) : '0)
             | (rd_dat ? STB_MASK : '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_d  <= '1;
      sts    <= '0;
      en     <= '0;
      data_q <= '0;
      fbusy  <= 1'b0;
      fack   <= 1'b0;
      mode_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      lvl_d <= lvl;
      sts   <= (sts & ~clr) | evt;
      rst_q <= wr_ctl && reg_wdata[0];
      if (fall[STB_IDX]) data_q <= pd_q[SYNC_LEN-1];
      if (wr_en) en <= reg_wdata[NEVT-1:0];
      if (wr_ctl) mode_q <= reg_wdata[1];
      if (wr_lvl) begin
        fbusy <= reg_wdata[FBSY_BIT];
        fack  <= reg_wdata[FACK_BIT];
      end
    end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_LVL: begin
        reg_rdata[NPIN-1:0] = lvl;
        reg_rdata[FBSY_BIT] = fbusy;
        reg_rdata[FACK_BIT] = fack;
      end
      A_CTL:   reg_rdata[1] = mode_q;
      A_DAT:   reg_rdata[DATA_W-1:0] = data_q;
      A_STS:   reg_rdata[NEVT-1:0] = sts;
      A_EN:    reg_rdata[NEVT-1:0] = en;
      default: reg_rdata = '0;
    endcase
  end

  assign busy     = fbusy | eng_busy;
  assign ack_n    = ~(fack | eng_ack);
  assign sm_reset = rst_q;
  assign hs_mode  = mode_q;
  assign irq      = |(sts & en);
  assign unused_wdata = ^reg_wdata[REG_W-1:NEVT];
endmodule

// File: rtl/pp_host_irq_chk.sv
module pp_host_irq_chk #(
  parameter int NEVT = 13,
  parameter int NENG = 5,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [2:0]       reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [NENG-1:0]  eng_evt,
  input logic [NEVT-1:0]  sts,
  input logic             fbusy,
  input logic             fack,
  input logic             busy,
  input logic             ack_n,
  input logic             sm_reset
);
  a_r4_eng_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_evt != '0) |=> ((sts[NEVT-1 -: NENG] & $past(eng_evt)) == $past(eng_evt)));

  a_r6_strobe_fall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts[5]) |-> $past(reg_rd && reg_addr == 3'd2));

  a_r6_strobe_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts[1]) |-> $past(reg_rd && reg_addr == 3'd2));

  a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3 && reg_wdata[8] && !eng_evt[0]) |=> !sts[8]);

  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    eng_evt[0] |=> sts[8]);

  a_r11_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && reg_wdata[0]) |=> sm_reset);

  a_r11_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
    sm_reset |-> $past(reg_wr && reg_addr == 3'd1 && reg_wdata[0]));

  a_r9_force_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fbusy |-> busy);

  a_r10_force_ack: assert property (@(posedge clk) disable iff (!rst_n)
    fack |-> !ack_n);
endmodule

bind pp_host_irq pp_host_irq_chk #(.NEVT(NEVT), .NENG(NENG), .REG_W(REG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .eng_evt(eng_evt),
  .sts(sts), .fbusy(fbusy), .fack(fack), .busy(busy), .ack_n(ack_n),
  .sm_reset(sm_reset)
);

// File: tb/pp_host_irq_tb_top.sv
module pp_host_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slctin_n = 1'b1, strobe_n = 1'b1, init_n = 1'b1, autofd_n = 1'b1;
  logic [7:0]  pdata = 8'h00;
  logic [4:0]  eng_evt = '0;
  logic        eng_busy = 1'b0, eng_ack = 1'b0;
  logic        busy, ack_n, sm_reset, hs_mode, irq;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pp_host_irq dut_i (
    .clk(clk), .rst_n(rst_n), .slctin_n(slctin_n), .strobe_n(strobe_n),
    .init_n(init_n), .autofd_n(autofd_n), .pdata(pdata), .eng_evt(eng_evt),
    .eng_busy(eng_busy), .eng_ack(eng_ack), .busy(busy), .ack_n(ack_n),
    .sm_reset(sm_reset), .hs_mode(hs_mode), .irq(irq), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    peek(3, d); check("R1 status", d, 16'h0000);
    peek(4, d); check("R1 enable", d, 16'h0000);
    peek(0, d); check("R1 levels", d, 16'h000F);
    peek(1, d); check("R1 mode", d, 16'h0000);
    check("R1 irq", irq, 0);
    check("R1 sm_reset", sm_reset, 0);
    check("R1 busy", busy, 0);
    check("R1 ack_n", ack_n, 1);
  endtask

  task automatic t_filter_edges();
    logic [15:0] d;
    @(negedge clk); init_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 reg_addr = 3'd0; #1 check("R2 level not yet", reg_rdata[2], 1);
    @(posedge clk);
    #1 reg_addr = 3'd0; #1 check("R2 level after 6 edges", reg_rdata[2], 0);
    reg_addr = 3'd3; #1 check("R3 status lags level", reg_rdata, 16'h0000);
    @(posedge clk);
    #1 check("R3 init fall bit6", reg_rdata, 16'h0040);
    wr_reg(3, 16'h0040);
    peek(3, d); check("R5 w1c clears bit6", d, 16'h0000);
    @(negedge clk); init_n = 1'b1;
    settle();
    peek(3, d); check("R3 init rise bit2", d, 16'h0004);
    wr_reg(3, 16'h0000);
    peek(3, d); check("R5 write zero keeps", d, 16'h0004);
    wr_reg(3, 16'h0004);
    @(negedge clk); autofd_n = 1'b0;
    repeat (2) @(negedge clk); autofd_n = 1'b1;
    settle();
    peek(0, d); check("R2 2-cycle glitch level", d[3], 1);
    peek(3, d); check("R2 2-cycle glitch no event", d, 16'h0000);
    @(negedge clk); autofd_n = 1'b0;
    repeat (3) @(negedge clk); autofd_n = 1'b1;
    settle();
    peek(3, d); check("R2 3-cycle pulse accepted", d, 16'h0088);
    @(negedge clk); slctin_n = 1'b0;
    settle();
    peek(0, d); check("R2 slctin level bit0", d[3:0], 4'hE);
    peek(3, d); check("R3 slctin fall bit4", d, 16'h0098);
    wr_reg(3, 16'hFFFF);
    @(negedge clk); slctin_n = 1'b1;
    settle();
    wr_reg(3, 16'hFFFF);
    peek(3, d); check("R5 all cleared", d, 16'h0000);
  endtask

  task automatic t_strobe();
    logic [15:0] d;
    @(negedge clk); pdata = 8'hA5; strobe_n = 1'b0;
    settle();
    pdata = 8'h3C;
    settle();
    peek(3, d); check("R3 strobe fall bit5", d, 16'h0020);
    wr_reg(3, 16'hFFFF);
    peek(3, d); check("R5 w1c ignores strobe bit", d, 16'h0020);
    rd_reg(2, d); check("R7 data latched mode0", d, 16'h00A5);
    peek(3, d); check("R6 data read clears bit5", d, 16'h0000);
    @(negedge clk); strobe_n = 1'b1;
    settle();
    peek(3, d); check("R3 strobe rise bit1", d, 16'h0002);
    rd_reg(2, d); check("R7 data held after rise", d, 16'h00A5);
    peek(3, d); check("R6 data read clears bit1", d, 16'h0000);
    wr_reg(1, 16'h0002);
    check("R11 hs_mode", hs_mode, 1);
    peek(1, d); check("R11 mode readback", d, 16'h0002);
    @(negedge clk); pdata = 8'h5A; strobe_n = 1'b0;
    settle();
    rd_reg(2, d); check("R7 data latched mode1", d, 16'h005A);
    @(negedge clk); strobe_n = 1'b1;
    settle();
    rd_reg(2, d);
    peek(3, d); check("R6 cleared after second read", d, 16'h0000);
  endtask

  task automatic t_engine();
    logic [15:0] d;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); eng_evt = 5'(1 << i);
      @(negedge clk); eng_evt = '0;
      #1 reg_addr = 3'd3; #1;
      check("R4 engine event bit", reg_rdata, 32'(1 << (8 + i)));
      wr_reg(3, 16'hFFFF);
    end
  endtask

  task automatic t_enable();
    logic [15:0] d;
    wr_reg(4, 16'hFFFF);
    peek(4, d); check("R8 enable width", d, 16'h1FFF);
    check("R8 irq idle", irq, 0);
    @(negedge clk); eng_evt = 5'b00100;
    @(negedge clk); eng_evt = '0;
    #1 check("R8 irq raised", irq, 1);
    peek(3, d); check("R8 status upper zero", d, 16'h0400);
    wr_reg(4, 16'h1BFF);
    check("R8 irq masked", irq, 0);
    wr_reg(4, 16'h0400);
    check("R8 irq unmasked", irq, 1);
    wr_reg(3, 16'h0400);
    check("R8 irq after clear", irq, 0);
    wr_reg(4, 16'h0000);
  endtask

  task automatic t_busy_ack();
    logic [15:0] d;
    @(negedge clk); eng_busy = 1'b1; eng_ack = 1'b1;
    #1 check("R9 engine busy", busy, 1);
    check("R10 engine ack", ack_n, 0);
    eng_busy = 1'b0; eng_ack = 1'b0;
    #1 check("R9 busy released", busy, 0);
    check("R10 ack released", ack_n, 1);
    wr_reg(0, 16'h0100);
    check("R9 forced busy", busy, 1);
    check("R10 ack not forced", ack_n, 1);
    peek(0, d); check("R9 force readback", d, 16'h010F);
    wr_reg(0, 16'h0200);
    check("R9 busy unforced", busy, 0);
    check("R10 forced ack", ack_n, 0);
    wr_reg(0, 16'h0000);
    check("R10 ack unforced", ack_n, 1);
  endtask

  task automatic t_sm_reset();
    wr_reg(1, 16'h0001);
    check("R11 reset pulse high", sm_reset, 1);
    check("R11 mode cleared by write", hs_mode, 0);
    @(negedge clk);
    check("R11 reset pulse single", sm_reset, 0);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    @(negedge clk); eng_evt = 5'b00001;
    @(negedge clk);
    reg_addr = 3'd3; reg_wdata = 16'h0100; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; eng_evt = '0;
    peek(3, d); check("R12 set beats clear", d, 16'h0100);
    wr_reg(3, 16'h0100);
    peek(3, d); check("R12 clear alone", d, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_filter_edges();
    t_strobe();
    t_engine();
    t_enable();
    t_busy_ack();
    t_sm_reset();
    t_set_wins();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule